// File: doc/BRIEF.md
# GMII Test-Frame Traffic Generator

This block produces Ethernet test frames directly on an 8-bit GMII transmit bus, with no MAC in between. The host loads a frame template, byte by byte, into an internal block-RAM buffer through a simple write port. While `run` is high the block replays that template as complete frames. It adds the preamble and start delimiter in front of the template, appends a CRC-32 frame check sequence after it, and keeps a fixed idle gap between frames.

An optional dynamic mode overwrites two fields of every frame. One field gets a 64-bit sequence number that counts up from zero. The other gets a timestamp sampled from `ts_now` as the start delimiter goes out. A receiver can use both to measure loss, ordering and latency.

Three controls set how many frames go out. A total-frame limit stops the run after an exact count. A burst setting groups frames and inserts a programmable pause between groups. Dropping `run` stops the stream at the next frame boundary.

Top module: `tgen_gmii`

## Requirements
- R1: While `rst` is high, and after reset for as long as `run` stays low, `gmii_tx_en` is 0 and `gmii_txd` is 0x00.
- R2: Each frame on the bus has the following parts, in this order:
  - seven bytes of 0x55 and then one byte of 0xD5;
  - template bytes at addresses 0 to `cfg_len`-1, in address order;
  - four FCS bytes, least significant byte first. The FCS is the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones, result complemented) over the transmitted template bytes.
  
  `gmii_txd` is 0x00 whenever `gmii_tx_en` is low.
- R3: Consecutive frames in a stream are separated by exactly 12 cycles with `gmii_tx_en` low, and never by fewer than 12.
- R4: With `cfg_dyn` high, frame bytes SEQ_OFS to SEQ_OFS+7 (default 40) carry the frame's sequence number, most significant byte first. The first frame after `run` rises carries 0, and each later frame carries one more. Frame bytes TS_OFS to TS_OFS+9 (default 48) carry `ts_now`, most significant byte first, as sampled on the clock edge that puts 0xD5 on the bus. The FCS covers these inserted bytes.
- R5: With `cfg_total` nonzero, exactly `cfg_total` frames are sent per assertion of `run`. With `cfg_total` zero, frames continue for as long as `run` stays high.
- R6: With `cfg_burst_len` = B nonzero, after every B frames the idle gap becomes 12 + `cfg_burst_gap` cycles. With B zero, every gap is 12 cycles.
- R7: When `run` falls, the frame already on the bus finishes intact and no new frame starts. Raising `run` again restarts the sequence number at 0 and restarts the total-frame count.
- R8: A host write while a frame is reading the buffer is held until that frame's data phase ends. The frame in flight carries the old byte and the next frame carries the new one. A write while no frame is reading takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Generation enable |
| cfg_len | input | ADDR_W+1 | Template length in bytes, FCS excluded |
| cfg_dyn | input | 1 | Insert sequence number and timestamp |
| cfg_total | input | CNT_W | Frames per run, 0 for unlimited |
| cfg_burst_len | input | BURST_W | Frames per burst, 0 for no bursts |
| cfg_burst_gap | input | BURST_W | Extra idle cycles after each burst |
| ts_now | input | TS_W | Current time value |
| host_wr_en | input | 1 | Template byte write strobe |
| host_wr_addr | input | ADDR_W | Template byte address |
| host_wr_data | input | 8 | Template byte value |
| gmii_txd | output | 8 | GMII transmit data |
| gmii_tx_en | output | 1 | GMII transmit enable |

## Verification
The assertions take three things for granted about the inputs. First, the host issues at most one buffer write per frame while a frame is reading the buffer. Second, `cfg_len` is held steady at a value large enough to contain both inserted fields. Third, configuration changes only while `run` is low.

The stimulus keeps to these limits. It loads the whole template while the bus is idle, reconfigures only between runs with `run` low, and issues a single write in the middle of a frame for the deferral case.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    localparam logic [7:0]  PRE_BYTE  = 8'h55;
    localparam logic [7:0]  SFD_BYTE  = 8'hD5;
    localparam int          PRE_LEN   = 8;
    localparam int          FCS_LEN   = 4;
    localparam int          IFG_BYTES = 12;
    localparam int          SEQ_BYTES = 8;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    // Per-frame settings captured at launch
    typedef struct packed {
        logic [15:0] len;
        logic        dyn;
        logic [63:0] seq;
    } frame_cfg_t;

    // Pending host write held during a frame
    typedef struct packed {
        logic        valid;
        logic [15:0] addr;
        logic [7:0]  data;
    } held_wr_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tgen_frame_buf.sv
module tgen_frame_buf
    import tgen_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              hold,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              pend_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]        mem [DEPTH];
    held_wr_t          held_q;
    logic              we_c;
    logic [ADDR_W-1:0] wa_c;
    logic [7:0]        wd_c;

    // Memory port write selection: a held write drains first
    always_comb begin
        we_c = 1'b0;
        wa_c = wr_addr;
        wd_c = wr_data;
        if (!hold && held_q.valid) begin
            we_c = 1'b1;
            wa_c = held_q.addr[ADDR_W-1:0];
            wd_c = held_q.data;
        end else if (!hold && wr_en) begin
            we_c = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (wr_en && (hold || held_q.valid)) begin
            held_q.valid <= 1'b1;
            held_q.addr  <= 16'(wr_addr);
            held_q.data  <= wr_data;
        end else if (!hold && held_q.valid) begin
            held_q.valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (we_c) mem[wa_c] <= wd_c;
        rd_data <= mem[rd_addr];
    end

    assign pend_valid = held_q.valid;

endmodule

// File: rtl/tgen_sched.sv
module tgen_sched #(
    parameter int CNT_W   = 32,
    parameter int BURST_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [CNT_W-1:0]   cfg_total,
    input  logic [BURST_W-1:0] cfg_burst_len,
    input  logic [BURST_W-1:0] cfg_burst_gap,
    input  logic               ready,
    output logic               start,
    output logic [63:0]        seq
);
    logic [CNT_W-1:0]   sent_q;
    logic [BURST_W-1:0] burst_q;
    logic [BURST_W-1:0] pause_q;
    logic               arm_q;
    logic [63:0]        seq_q;
    logic               limit_hit;
    logic               hold_off;

    assign limit_hit = (cfg_total != '0) && (sent_q == cfg_total);
    assign hold_off  = arm_q ? (cfg_burst_gap != '0) : (pause_q != '0);
    assign start     = ready && run && !limit_hit && !hold_off;
    assign seq       = seq_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sent_q  <= '0;
            burst_q <= '0;
            pause_q <= '0;
            arm_q   <= 1'b0;
            seq_q   <= '0;
        end else begin
            if (ready && arm_q) begin
                arm_q   <= 1'b0;
                pause_q <= (cfg_burst_gap == '0) ? '0 : cfg_burst_gap - 1'b1;
            end else if (pause_q != '0) begin
                pause_q <= pause_q - 1'b1;
            end
            if (start) begin
                sent_q <= sent_q + 1'b1;
                seq_q  <= seq_q + 64'd1;
                if (cfg_burst_len != '0 && burst_q + 1'b1 == cfg_burst_len) begin
                    arm_q   <= 1'b1;
                    burst_q <= '0;
                end else begin
                    burst_q <= burst_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tgen_tx_engine.sv
module tgen_tx_engine
    import tgen_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int TS_W    = 80,
    parameter int SEQ_OFS = 40,
    parameter int TS_OFS  = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_cfg_t        cfg_in,
    input  logic [TS_W-1:0]   ts_now,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ready,
    output logic              busy,
    output logic [7:0]        txd,
    output logic              tx_en
);
    localparam int          TS_BYTES = TS_W / 8;
    localparam logic [15:0] GAP_LAST = 16'(IFG_BYTES - 2);

    tx_state_e         st_q;
    logic [15:0]       cnt_q;
    frame_cfg_t        cfg_q;
    logic [TS_W-1:0]   ts_q;
    logic [31:0]       crc_q;
    logic [7:0]        txd_q;
    logic              txen_q;
    logic [7:0]        data_byte;
    logic [7:0]        next_byte;
    logic              in_seq;
    logic              in_ts;
    logic [63:0]       seq_sh;
    logic [TS_W-1:0]   ts_sh;

    assign in_seq = cfg_q.dyn && (int'(cnt_q) >= SEQ_OFS) && (int'(cnt_q) < SEQ_OFS + SEQ_BYTES);
    assign in_ts  = cfg_q.dyn && (int'(cnt_q) >= TS_OFS)  && (int'(cnt_q) < TS_OFS + TS_BYTES);

    // Field insertion over the buffer byte
    always_comb begin
        seq_sh = cfg_q.seq >> (8 * (SEQ_BYTES - 1 - (int'(cnt_q) - SEQ_OFS)));
        ts_sh  = ts_q >> (8 * (TS_BYTES - 1 - (int'(cnt_q) - TS_OFS)));
        if (in_seq)     data_byte = seq_sh[7:0];
        else if (in_ts) data_byte = ts_sh[7:0];
        else            data_byte = rd_data;
    end

    always_comb begin
        unique case (st_q)
            ST_PRE:  next_byte = (cnt_q == 16'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
            ST_DATA: next_byte = data_byte;
            ST_FCS:  next_byte = ~crc_q[8*cnt_q[1:0] +: 8];
            default: next_byte = 8'h00;
        endcase
    end

    assign rd_addr = (st_q == ST_DATA) ? ADDR_W'(cnt_q + 16'd1) : '0;
    assign ready   = (st_q == ST_IDLE);
    assign busy    = (st_q == ST_PRE) || (st_q == ST_DATA);
    assign txd     = txd_q;
    assign tx_en   = txen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            cfg_q  <= '0;
            ts_q   <= '0;
            crc_q  <= '1;
            txd_q  <= 8'h00;
            txen_q <= 1'b0;
        end else begin
            txd_q  <= next_byte;
            txen_q <= (st_q == ST_PRE) || (st_q == ST_DATA) || (st_q == ST_FCS);
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_PRE;
                        cnt_q <= '0;
                        cfg_q <= cfg_in;
                    end
                end
                ST_PRE: begin
                    crc_q <= '1;
                    if (cnt_q == 16'(PRE_LEN - 1)) begin
                        ts_q  <= ts_now;
                        st_q  <= ST_DATA;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 16'd1;
                    end
                end
                ST_DATA: begin
                    crc_q <= crc32_step(crc_q, data_byte);
                    if (cnt_q == cfg_q.len - 16'd1) begin
                        st_q  <= ST_FCS;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 16'd1;
                    end
                end
                ST_FCS: begin
                    if (cnt_q == 16'(FCS_LEN - 1)) begin
                        st_q  <= ST_GAP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 16'd1;
                    end
                end
                default: begin
                    if (cnt_q == GAP_LAST) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 16'd1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/tgen_gmii.sv
module tgen_gmii
    import tgen_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int TS_W    = 80,
    parameter int CNT_W   = 32,
    parameter int BURST_W = 16,
    parameter int SEQ_OFS = 40,
    parameter int TS_OFS  = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [ADDR_W:0]    cfg_len,
    input  logic               cfg_dyn,
    input  logic [CNT_W-1:0]   cfg_total,
    input  logic [BURST_W-1:0] cfg_burst_len,
    input  logic [BURST_W-1:0] cfg_burst_gap,
    input  logic [TS_W-1:0]    ts_now,
    input  logic               host_wr_en,
    input  logic [ADDR_W-1:0]  host_wr_addr,
    input  logic [7:0]         host_wr_data,
    output logic [7:0]         gmii_txd,
    output logic               gmii_tx_en
);
    logic              eng_ready;
    logic              buf_hold;
    logic              buf_pend;
    logic              launch;
    logic [63:0]       next_seq;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    frame_cfg_t        launch_cfg;

    assign launch_cfg = '{len: 16'(cfg_len), dyn: cfg_dyn, seq: next_seq};

    tgen_frame_buf #(.ADDR_W(ADDR_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (host_wr_en),
        .wr_addr    (host_wr_addr),
        .wr_data    (host_wr_data),
        .hold       (buf_hold),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .pend_valid (buf_pend)
    );

    tgen_sched #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_sched (
        .clk           (clk),
        .rst           (rst),
        .run           (run),
        .cfg_total     (cfg_total),
        .cfg_burst_len (cfg_burst_len),
        .cfg_burst_gap (cfg_burst_gap),
        .ready         (eng_ready),
        .start         (launch),
        .seq           (next_seq)
    );

    tgen_tx_engine #(
        .ADDR_W  (ADDR_W),
        .TS_W    (TS_W),
        .SEQ_OFS (SEQ_OFS),
        .TS_OFS  (TS_OFS)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (launch),
        .cfg_in  (launch_cfg),
        .ts_now  (ts_now),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .ready   (eng_ready),
        .busy    (buf_hold),
        .txd     (gmii_txd),
        .tx_en   (gmii_tx_en)
    );

endmodule

// File: rtl/tgen_gmii_chk.sv
module tgen_gmii_chk (
    input logic       clk,
    input logic       rst,
    input logic       run,
    input logic       tx_en,
    input logic [7:0] txd,
    input logic       wr_en,
    input logic       pend_valid,
    input logic       busy
);
    logic [7:0] idle_cnt;
    logic [7:0] pos_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= 8'hFF;
            pos_cnt  <= '0;
        end else begin
            idle_cnt <= tx_en ? 8'd0 : ((idle_cnt == 8'hFF) ? idle_cnt : idle_cnt + 8'd1);
            pos_cnt  <= !tx_en ? 8'd0 : ((pos_cnt == 8'hFF) ? pos_cnt : pos_cnt + 8'd1);
        end
    end

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> txd == 8'h00);  // R2
    AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> txd == 8'h55);  // R2
    AST_SFD_SLOT: assert property (@(posedge clk) disable iff (rst)
        (tx_en && pos_cnt == 8'd7) |-> txd == 8'hD5);  // R2
    AST_MIN_IFG: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> idle_cnt >= 8'd12);  // R3
    AST_RUN_GATES_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $past(run, 2));  // R7
    AST_NO_LOST_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |-> !pend_valid);  // R8

endmodule

bind tgen_gmii tgen_gmii_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .tx_en      (gmii_tx_en),
    .txd        (gmii_txd),
    .wr_en      (host_wr_en),
    .pend_valid (buf_pend),
    .busy       (buf_hold)
);

// File: tb/tgen_gmii_tb.sv
module tgen_gmii_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        run;
    logic [7:0]  cfg_len;
    logic        cfg_dyn;
    logic [31:0] cfg_total;
    logic [15:0] cfg_burst_len;
    logic [15:0] cfg_burst_gap;
    logic [79:0] ts_now;
    logic        host_wr_en;
    logic [6:0]  host_wr_addr;
    logic [7:0]  host_wr_data;
    logic [7:0]  gmii_txd;
    logic        gmii_tx_en;

    always #5 clk = ~clk;

    tgen_gmii u_dut (
        .clk           (clk),
        .rst           (rst),
        .run           (run),
        .cfg_len       (cfg_len),
        .cfg_dyn       (cfg_dyn),
        .cfg_total     (cfg_total),
        .cfg_burst_len (cfg_burst_len),
        .cfg_burst_gap (cfg_burst_gap),
        .ts_now        (ts_now),
        .host_wr_en    (host_wr_en),
        .host_wr_addr  (host_wr_addr),
        .host_wr_data  (host_wr_data),
        .gmii_txd      (gmii_txd),
        .gmii_tx_en    (gmii_tx_en)
    );

    typedef struct {
        int    seq;
        int    len;
        bit    dyn;
        int    gap;
        string gap_tag;
    } item_t;

    item_t       exp_q[$];
    logic [7:0]  shadow [128];
    logic [7:0]  snap [128];
    logic [7:0]  cur[$];
    logic [79:0] ts_cap;
    int          frames_seen = 0;
    int          idle_n = 1000;
    int          gap_start = 0;
    logic        prev_en = 1'b0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;

    function automatic void check(input bit ok, input string req, input string what,
                                  input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic logic [31:0] ref_fcs(input logic [7:0] b[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (b[i]) begin
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ b[i][k];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    function automatic void finish_frame();
        item_t       it;
        logic [7:0]  body[$];
        logic [7:0]  expv[$];
        logic [31:0] f;
        logic [63:0] sq;
        int          bad_at = -1;
        frames_seen++;
        if (exp_q.size() == 0) begin
            check(0, "R5", "unexpected frame", frames_seen, 0);
            return;
        end
        it = exp_q.pop_front();
        sq = 64'(it.seq);
        for (int k = 0; k < it.len; k++) begin
            logic [7:0] v = snap[k];
            if (it.dyn && k >= 40 && k < 48) v = 8'(sq >> (8 * (47 - k)));
            if (it.dyn && k >= 48 && k < 58) v = 8'(ts_cap >> (8 * (57 - k)));
            body.push_back(v);
        end
        f = ref_fcs(body);
        for (int k = 0; k < 7; k++) expv.push_back(8'h55);
        expv.push_back(8'hD5);
        foreach (body[k]) expv.push_back(body[k]);
        for (int k = 0; k < 4; k++) expv.push_back(f[8*k +: 8]);
        check(cur.size() == expv.size(), it.dyn ? "R4" : "R2", "frame length",
              cur.size(), expv.size());
        for (int k = 0; k < expv.size() && k < cur.size(); k++)
            if (bad_at < 0 && cur[k] !== expv[k]) bad_at = k;
        if (bad_at >= 0)
            check(0, it.dyn ? "R4" : "R2", $sformatf("byte %0d", bad_at),
                  cur[bad_at], expv[bad_at]);
        else
            check(1, "R2", "content", 0, 0);
        if (it.gap != 0)
            check(gap_start == it.gap, it.gap_tag, "idle gap", gap_start, it.gap);
    endfunction

    // Monitor
    always @(negedge clk) begin
        if (gmii_tx_en) begin
            if (!prev_en) begin
                gap_start = idle_n;
                cur.delete();
            end
            cur.push_back(gmii_txd);
            if (cur.size() == 8) begin
                ts_cap = ts_now - 80'd1;
                snap   = shadow;
            end
            idle_n = 0;
        end else begin
            if (prev_en) finish_frame();
            if (!rst) check(gmii_txd == 8'h00, "R2", "idle data", gmii_txd, 0);
            idle_n++;
        end
        prev_en = gmii_tx_en;
    end

    initial begin
        ts_now = 80'h0123_4567_89AB_CDEF_0000;
        forever begin
            @(posedge clk);
            #1;
            ts_now = ts_now + 80'd1;
        end
    end

    task automatic host_write(input int a, input logic [7:0] d, input bit upd);
        @(negedge clk);
        host_wr_en   = 1'b1;
        host_wr_addr = 7'(a);
        host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        if (upd) shadow[a] = d;
    endtask

    task automatic wait_frames(input int target);
        int t = 0;
        while (frames_seen < target && t < 8000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic run_case(input int total, input int blen, input int bgap,
                            input int len, input bit dyn, input int n);
        int base = frames_seen;
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.seq = i;
            it.len = len;
            it.dyn = dyn;
            it.gap_tag = "R3";
            if (i == 0) it.gap = 0;
            else if (blen != 0 && (i % blen) == 0) begin
                it.gap = 12 + bgap;
                it.gap_tag = "R6";
            end else it.gap = 12;
            exp_q.push_back(it);
        end
        @(negedge clk);
        cfg_total = 32'(total);
        cfg_burst_len = 16'(blen);
        cfg_burst_gap = 16'(bgap);
        cfg_len = 8'(len);
        cfg_dyn = dyn;
        run = 1'b1;
        wait_frames(base + n);
        repeat (300) @(negedge clk);
        check(frames_seen == base + n, "R5", "frames per run", frames_seen - base, n);
        check(exp_q.size() == 0, "R5", "frames outstanding", exp_q.size(), 0);
        exp_q.delete();
        run = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        rst = 1'b1;
        run = 1'b0;
        cfg_len = 8'd60;
        cfg_dyn = 1'b0;
        cfg_total = '0;
        cfg_burst_len = '0;
        cfg_burst_gap = '0;
        host_wr_en = 1'b0;
        host_wr_addr = '0;
        host_wr_data = '0;
        for (int k = 0; k < 128; k++) shadow[k] = 8'h00;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(gmii_tx_en == 1'b0 && gmii_txd == 8'h00, "R1", "bus during reset",
              {gmii_tx_en, gmii_txd}, 0);
        rst = 1'b0;
        // R8: loads while idle land at once
        for (int k = 0; k < 128; k++) host_write(k, 8'(k * 7 + 3), 1'b1);
        repeat (20) @(negedge clk);
        check(frames_seen == 0 && gmii_tx_en == 1'b0, "R1", "no frames with run low",
              frames_seen, 0);

        run_case(3, 0, 0, 60, 1'b0, 3);    // R2 R3 R5 fixed count, static
        run_case(4, 0, 0, 60, 1'b1, 4);    // R4 R7 seq restarts at 0
        run_case(6, 2, 30, 60, 1'b1, 6);   // R6 bursts with pause
        run_case(3, 1, 5, 61, 1'b1, 3);    // R6 single-frame bursts, odd length
        run_case(3, 2, 0, 64, 1'b0, 3);    // R6 zero pause

        // R5 unlimited and R7 disable mid-frame
        base = frames_seen;
        for (int i = 0; i < 10; i++) begin
            item_t it;
            it.seq = i; it.len = 60; it.dyn = 1'b1;
            it.gap = (i == 0) ? 0 : 12; it.gap_tag = "R3";
            exp_q.push_back(it);
        end
        @(negedge clk);
        cfg_total = '0; cfg_burst_len = '0; cfg_len = 8'd60; cfg_dyn = 1'b1;
        run = 1'b1;
        wait_frames(base + 3);
        while (!gmii_tx_en || cur.size() < 20) @(negedge clk);
        run = 1'b0;
        repeat (300) @(negedge clk);
        check(frames_seen == base + 4, "R7", "frames after disable", frames_seen - base, 4);
        exp_q.delete();

        // R8 write during a frame is deferred
        base = frames_seen;
        for (int i = 0; i < 2; i++) begin
            item_t it;
            it.seq = i; it.len = 60; it.dyn = 1'b0;
            it.gap = (i == 0) ? 0 : 12; it.gap_tag = "R3";
            exp_q.push_back(it);
        end
        @(negedge clk);
        cfg_total = 32'd2; cfg_dyn = 1'b0;
        run = 1'b1;
        while (!gmii_tx_en || cur.size() < 20) @(negedge clk);
        host_write(50, 8'hA5, 1'b0);
        while (gmii_tx_en) @(negedge clk);
        shadow[50] = 8'hA5;
        wait_frames(base + 2);
        repeat (50) @(negedge clk);
        check(frames_seen == base + 2 && exp_q.size() == 0, "R8", "deferred write frames",
              frames_seen - base, 2);
        run = 1'b0;
        repeat (20) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule